// File: doc/BRIEF.md
# BCD Adjust Unit

This block applies the four decimal-correction steps to a 16-bit accumulator that is split into a high byte and a low byte. Two of the steps repair a low byte after an add or a subtract of unpacked decimal digits. They do this by adding or removing six, and they move a carry or borrow into the high byte. The other two steps convert between a two-digit unpacked value and its binary equivalent. One folds the high digit into the low byte with a multiply by ten. The other splits a binary low byte into a quotient digit and a remainder digit with a divide by ten.

A request is given by a 2-bit operation select, the accumulator, the incoming auxiliary-carry flag and a one-cycle valid strobe. One clock later the block presents the corrected accumulator, the carry, auxiliary-carry, zero, sign and parity flags, and an output valid. A two-state sequencer tracks whether a result is being presented. In `ST_IDLE` nothing is presented. In `ST_OUT` the registered result of the previous request is on the outputs. From either state, `in_valid` high leads to `ST_OUT` and `in_valid` low leads to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `bcd_adjust_unit`

## Requirements
- R1: With op_sel = 00 (add-correct), if the low nibble of the low byte is above 9 or af_in is 1, the low byte gains 6 modulo 256, the high byte gains 1, and cf_out and af_out are both 1.
- R2: With op_sel = 00 or 01 and the correction condition false, the high byte is unchanged and cf_out and af_out are 0. In every add-correct and subtract-correct result, bits 7:4 of the low byte are 0, whichever branch was taken.
- R3: With op_sel = 01 (subtract-correct), the condition of R1 is used. When it holds, the low byte loses 6 modulo 256, the high byte loses 1, and cf_out and af_out are 1.
- R4: With op_sel = 10 (merge-before-divide), the new low byte is (high byte × 10 + low byte) truncated to 8 bits, and the new high byte is 0.
- R5: With op_sel = 11 (split-after-multiply), the new high byte is the low byte divided by 10 and the new low byte is the remainder. The incoming high byte has no effect.
- R6: For op_sel 10 and 11, zf_out is 1 when the result low byte is 0, sf_out equals bit 7 of that byte, and pf_out is 1 when that byte has an even number of set bits.
- R7: For op_sel 00 and 01, zf_out, sf_out and pf_out are 0. For op_sel 10 and 11, cf_out and af_out are 0.
- R8: out_valid is 1 in exactly the cycle after each cycle with in_valid high. Back-to-back requests each give their own result one cycle later.
- R9: While in_valid is low, acc_out and all flag outputs keep their last values, whatever the other inputs do.
- R10: After reset, out_valid, acc_out and all flag outputs are 0.
- R11: High-byte arithmetic wraps modulo 256. Add-correct on high byte 0xFF gives 0x00, and subtract-correct on high byte 0x00 gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 00 add-correct, 01 subtract-correct, 10 merge-before-divide, 11 split-after-multiply |
| acc_in | input | 16 | Accumulator; bits 15:8 high byte, 7:0 low byte |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| out_valid | output | 1 | Result presented this cycle |
| acc_out | output | 16 | Corrected accumulator |
| cf_out | output | 1 | Carry flag |
| af_out | output | 1 | Auxiliary-carry flag |
| zf_out | output | 1 | Zero flag |
| sf_out | output | 1 | Sign flag |
| pf_out | output | 1 | Parity flag (even) |

## Verification
Two events can fall in the same cycle. One is the presentation of a registered result. The other is the capture of a new request that overwrites it. The bench provokes this by holding in_valid high on consecutive cycles with different operations. It judges each result one cycle after its own request, and it checks that out_valid stays high throughout. The hold path is exercised separately by changing every input while in_valid is low and confirming that the outputs do not move.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

    typedef enum logic [1:0] {
        OP_ADD_FIX   = 2'b00,
        OP_SUB_FIX   = 2'b01,
        OP_MERGE_TEN = 2'b10,
        OP_SPLIT_TEN = 2'b11
    } bcd_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } out_state_e;

endpackage

// File: rtl/bcd_nibble_fix.sv
// Low-nibble decimal correction shared by the add and subtract forms.
module bcd_nibble_fix #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic [BYTE_W-1:0] lo_byte,
    input  logic              aux_in,
    input  logic              subtract,
    output logic [BYTE_W-1:0] hi_fixed,
    output logic [BYTE_W-1:0] lo_fixed,
    output logic              fix_taken
);
    localparam int NIB_W = BYTE_W / 2;
    localparam logic [NIB_W-1:0]  NIB_MAX = NIB_W'(9);
    localparam logic [BYTE_W-1:0] SIX     = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] ONE     = BYTE_W'(1);

    logic [BYTE_W-1:0] lo_shift;
    logic [BYTE_W-1:0] hi_shift;

    always_comb begin
        fix_taken = (lo_byte[NIB_W-1:0] > NIB_MAX) || aux_in;
        lo_shift  = lo_byte;
        hi_shift  = hi_byte;
        if (fix_taken) begin
            if (subtract) begin
                lo_shift = lo_byte - SIX;
                hi_shift = hi_byte - ONE;
            end else begin
                lo_shift = lo_byte + SIX;
                hi_shift = hi_byte + ONE;
            end
        end
        lo_fixed = {{(BYTE_W-NIB_W){1'b0}}, lo_shift[NIB_W-1:0]};
        hi_fixed = hi_shift;
    end
endmodule

// File: rtl/bcd_ten_conv.sv
// Multiply-by-ten merge and divide-by-ten split of a two-digit value.
module bcd_ten_conv #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic [BYTE_W-1:0] lo_byte,
    output logic [BYTE_W-1:0] merged,
    output logic [BYTE_W-1:0] split_hi,
    output logic [BYTE_W-1:0] split_lo
);
    localparam logic [BYTE_W-1:0] TEN = BYTE_W'(10);

    always_comb begin
        merged   = hi_byte * TEN + lo_byte;
        split_hi = lo_byte / TEN;
        split_lo = lo_byte % TEN;
    end
endmodule

// File: rtl/bcd_flag_gen.sv
// Zero, sign and even-parity of a result byte.
module bcd_flag_gen #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] value,
    output logic              zero,
    output logic              sign,
    output logic              parity
);
    always_comb begin
        zero   = (value == '0);
        sign   = value[BYTE_W-1];
        parity = ~(^value);
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
    import bcd_adj_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int ACC_W = 2 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             af_in,
    output logic             out_valid,
    output logic [ACC_W-1:0] acc_out,
    output logic             cf_out,
    output logic             af_out,
    output logic             zf_out,
    output logic             sf_out,
    output logic             pf_out
);
    bcd_op_e           op;
    out_state_e        state_q;
    out_state_e        state_d;
    logic [BYTE_W-1:0] hi_in;
    logic [BYTE_W-1:0] lo_in;

    logic [BYTE_W-1:0] fix_hi;
    logic [BYTE_W-1:0] fix_lo;
    logic              fix_taken;
    logic [BYTE_W-1:0] merged;
    logic [BYTE_W-1:0] split_hi;
    logic [BYTE_W-1:0] split_lo;

    logic [BYTE_W-1:0] nxt_hi;
    logic [BYTE_W-1:0] nxt_lo;
    logic              nxt_carry;
    logic              use_result_flags;
    logic              byte_zero;
    logic              byte_sign;
    logic              byte_parity;

    assign op    = bcd_op_e'(op_sel);
    assign hi_in = acc_in[ACC_W-1:BYTE_W];
    assign lo_in = acc_in[BYTE_W-1:0];

    bcd_nibble_fix #(.BYTE_W(BYTE_W)) u_fix (
        .hi_byte  (hi_in),
        .lo_byte  (lo_in),
        .aux_in   (af_in),
        .subtract (op == OP_SUB_FIX),
        .hi_fixed (fix_hi),
        .lo_fixed (fix_lo),
        .fix_taken(fix_taken)
    );

    bcd_ten_conv #(.BYTE_W(BYTE_W)) u_ten (
        .hi_byte (hi_in),
        .lo_byte (lo_in),
        .merged  (merged),
        .split_hi(split_hi),
        .split_lo(split_lo)
    );

    // Result selection by operation.
    always_comb begin
        nxt_hi           = '0;
        nxt_lo           = '0;
        nxt_carry        = 1'b0;
        use_result_flags = 1'b0;
        unique case (op)
            OP_ADD_FIX, OP_SUB_FIX: begin
                nxt_hi    = fix_hi;
                nxt_lo    = fix_lo;
                nxt_carry = fix_taken;
            end
            OP_MERGE_TEN: begin
                nxt_hi           = '0;
                nxt_lo           = merged;
                use_result_flags = 1'b1;
            end
            OP_SPLIT_TEN: begin
                nxt_hi           = split_hi;
                nxt_lo           = split_lo;
                use_result_flags = 1'b1;
            end
        endcase
    end

    bcd_flag_gen #(.BYTE_W(BYTE_W)) u_flags (
        .value (nxt_lo),
        .zero  (byte_zero),
        .sign  (byte_sign),
        .parity(byte_parity)
    );

    // Sequencer: next state.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = in_valid ? ST_OUT : ST_IDLE;
        endcase
    end

    // Sequencer: state register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = (state_q == ST_OUT);

    // Output registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_out <= '0;
            cf_out  <= 1'b0;
            af_out  <= 1'b0;
            zf_out  <= 1'b0;
            sf_out  <= 1'b0;
            pf_out  <= 1'b0;
        end else if (in_valid) begin
            acc_out <= {nxt_hi, nxt_lo};
            cf_out  <= nxt_carry;
            af_out  <= nxt_carry;
            zf_out  <= use_result_flags & byte_zero;
            sf_out  <= use_result_flags & byte_sign;
            pf_out  <= use_result_flags & byte_parity;
        end
    end
endmodule

// File: rtl/bcd_adjust_checker.sv
module bcd_adjust_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  op_sel,
    input logic        out_valid,
    input logic [15:0] acc_out,
    input logic        cf_out,
    input logic        af_out,
    input logic        zf_out,
    input logic        sf_out,
    input logic        pf_out
);
    // R8
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drops_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(acc_out) && $stable(cf_out) && $stable(af_out)
                       && $stable(zf_out) && $stable(sf_out) && $stable(pf_out)));

    // R2
    p_upper_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_sel[1]) |=> (acc_out[7:4] == 4'h0));

    // R1, R3
    p_carry_pair_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_sel[1]) |=> (cf_out == af_out));

    // R7
    p_fix_flags_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_sel[1]) |=> (!zf_out && !sf_out && !pf_out));
    p_conv_carry_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel[1]) |=> (!cf_out && !af_out));

    // R4
    p_merge_hi_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b10) |=> (acc_out[15:8] == 8'h00));

    // R5
    p_split_digit_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b11) |=> (acc_out[7:0] < 8'd10 && acc_out[15:8] < 8'd26));

    // R6
    p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel[1]) |=> (zf_out == (acc_out[7:0] == 8'h00)));
endmodule

bind bcd_adjust_unit bcd_adjust_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op_sel   (op_sel),
    .out_valid(out_valid),
    .acc_out  (acc_out),
    .cf_out   (cf_out),
    .af_out   (af_out),
    .zf_out   (zf_out),
    .sf_out   (sf_out),
    .pf_out   (pf_out)
);

// File: tb/bcd_adjust_unit_bench.sv
module bcd_adjust_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [15:0] acc_in = 16'h0000;
    logic        af_in = 1'b0;
    logic        out_valid;
    logic [15:0] acc_out;
    logic        cf_out, af_out, zf_out, sf_out, pf_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bcd_adjust_unit u_bcd_adjust_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .acc_in(acc_in), .af_in(af_in), .out_valid(out_valid),
        .acc_out(acc_out), .cf_out(cf_out), .af_out(af_out),
        .zf_out(zf_out), .sf_out(sf_out), .pf_out(pf_out)
    );

    // Expected {acc[15:0], cf, af, zf, sf, pf} from the requirements.
    function automatic logic [20:0] expect_of(input logic [1:0] op,
                                              input logic [15:0] acc,
                                              input logic af);
        logic [7:0] hi, lo, orig;
        logic c, a, z, s, p;
        hi = acc[15:8]; lo = acc[7:0]; orig = lo;
        c = 0; a = 0; z = 0; s = 0; p = 0;
        if (op[1] == 1'b0) begin
            if (lo[3:0] > 4'd9 || af) begin
                lo = (op == 2'b00) ? lo + 8'd6 : lo - 8'd6;
                hi = (op == 2'b00) ? hi + 8'd1 : hi - 8'd1;
                c = 1; a = 1;
            end
            lo[7:4] = 4'h0;
        end else begin
            if (op == 2'b10) begin
                lo = hi * 8'd10 + orig;
                hi = 8'h00;
            end else begin
                hi = orig / 8'd10;
                lo = orig % 8'd10;
            end
            z = (lo == 8'h00);
            s = lo[7];
            p = ($countones(lo) % 2) == 0;
        end
        return {hi, lo, c, a, z, s, p};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_outputs(input string tag, input logic [20:0] e);
        chk({tag, " acc"}, acc_out, e[20:5]);
        chk({tag, " flags"}, {11'd0, cf_out, af_out, zf_out, sf_out, pf_out}, {11'd0, e[4:0]});
    endtask

    // Single request; outputs sampled on the following falling edge.
    task automatic run_one(input string tag, input logic [1:0] op,
                           input logic [15:0] acc, input logic af);
        @(negedge clk);
        in_valid = 1; op_sel = op; acc_in = acc; af_in = af;
        @(negedge clk);
        in_valid = 0;
        chk({tag, " valid R8"}, {15'd0, out_valid}, 16'd1);
        chk_outputs(tag, expect_of(op, acc, af));
    endtask

    task automatic t_reset;
        chk("R10 valid", {15'd0, out_valid}, 16'd0);
        chk("R10 acc", acc_out, 16'h0000);
        chk("R10 flags", {11'd0, cf_out, af_out, zf_out, sf_out, pf_out}, 16'd0);
    endtask

    task automatic t_add_fix;
        run_one("R1 add 000F", 2'b00, 16'h000F, 1'b0);
        chk("R1 add 000F literal", acc_out, 16'h0105);
        run_one("R1 add af", 2'b00, 16'h0003, 1'b1);
        chk("R1 add af literal", acc_out, 16'h0109);
        run_one("R1 add wraplo", 2'b00, 16'h0A7B, 1'b0);
        run_one("R2 add none", 2'b00, 16'h0435, 1'b0);
        chk("R2 add none literal", acc_out, 16'h0405);
        run_one("R7 add flags", 2'b00, 16'h0000, 1'b0);
    endtask

    task automatic t_sub_fix;
        run_one("R3 sub 02FF", 2'b01, 16'h02FF, 1'b0);
        chk("R3 sub 02FF literal", acc_out, 16'h0109);
        run_one("R3 sub af", 2'b01, 16'h0304, 1'b1);
        chk("R3 sub af literal", acc_out, 16'h020E);
        run_one("R2 sub none", 2'b01, 16'h0312, 1'b0);
    endtask

    task automatic t_merge;
        run_one("R4 merge 0105", 2'b10, 16'h0105, 1'b1);
        chk("R4 merge literal", acc_out, 16'h000F);
        run_one("R6 merge zero", 2'b10, 16'h0000, 1'b0);
        run_one("R6 merge sign", 2'b10, 16'h1905, 1'b0);
        run_one("R4 merge trunc", 2'b10, 16'h1A07, 1'b0);
        chk("R4 merge trunc literal", acc_out, 16'h000B);
    endtask

    task automatic t_split;
        run_one("R5 split 0F", 2'b11, 16'h000F, 1'b0);
        chk("R5 split literal", acc_out, 16'h0105);
        run_one("R5 split FF", 2'b11, 16'h00FF, 1'b1);
        chk("R5 split FF literal", acc_out, 16'h1905);
        run_one("R5 split hi ignored", 2'b11, 16'h7700, 1'b0);
        chk("R6 split zf", {15'd0, zf_out}, 16'd1);
    endtask

    task automatic t_wrap;
        run_one("R11 add hi wrap", 2'b00, 16'hFF0A, 1'b0);
        chk("R11 add hi wrap literal", acc_out, 16'h0000);
        run_one("R11 sub hi wrap", 2'b01, 16'h0000, 1'b1);
        chk("R11 sub hi wrap literal", acc_out, 16'hFF0A);
    endtask

    task automatic t_hold;
        logic [20:0] e;
        run_one("R9 base", 2'b11, 16'h0063, 1'b0);
        e = expect_of(2'b11, 16'h0063, 1'b0);
        for (int i = 0; i < 4; i++) begin
            op_sel = 2'(i); acc_in = 16'h5A5A ^ 16'(i); af_in = ~af_in;
            @(negedge clk);
            chk("R8 idle valid", {15'd0, out_valid}, 16'd0);
            chk_outputs("R9 hold", e);
        end
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        in_valid = 1; op_sel = 2'b00; acc_in = 16'h000F; af_in = 0;
        @(negedge clk);
        chk("R8 b2b first valid", {15'd0, out_valid}, 16'd1);
        chk_outputs("R8 b2b first", expect_of(2'b00, 16'h000F, 1'b0));
        op_sel = 2'b10; acc_in = 16'h0909;
        @(negedge clk);
        in_valid = 0;
        chk("R8 b2b second valid", {15'd0, out_valid}, 16'd1);
        chk_outputs("R8 b2b second", expect_of(2'b10, 16'h0909, 1'b0));
        @(negedge clk);
        chk("R8 b2b drop", {15'd0, out_valid}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_add_fix();
        t_sub_fix();
        t_merge();
        t_split();
        t_wrap();
        t_hold();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule